// File: doc/BRIEF.md
# Serial Character Transmitter with Idle Preamble and Break Insertion

This block drives a single serial output line, one bit per baud tick. Software-facing control arrives as plain inputs: a module enable, a transmit enable, a break request and a frame-size select. Characters of 8 data bits, or 8 data bits plus a ninth bit taken from a separate input, are written into a one-word holding buffer and then framed with a low start bit and a high stop bit.

Transmit enable is sampled only while the module enable is high. When transmit enable turns on with the line quiet, the block first emits a full frame of ones as a preamble. If enable is dropped and raised again while a frame is on the line, one all-ones idle frame is queued behind that frame. A break request emits all-zero frames back to back for as long as it is held. When it is released, a single 1 bit follows so that the next start bit can be seen. A break requested before a pending preamble starts takes the preamble's place.

Two flags report progress. The buffer-empty flag shows when a new word may be written. The done flag shows when the line is quiet with no work left.

Top module: `sertx_engine`

## Requirements
- R1: In 8-bit mode (`nine_bit`=0) a data frame is 10 bit times: a 0 start bit, then `wr_data` bit 0 through bit 7, then a 1 stop bit. Frames start only on a cycle with `baud_tick`=1, and each later `baud_tick` advances the line by one bit.
- R2: In 9-bit mode (`nine_bit`=1) a data frame is 11 bit times. The value of `bit9` at the moment the word leaves the buffer is sent after data bit 7 and before the stop bit.
- R3: When the registered transmit enable goes from 0 to 1 with no frame on the line, an all-ones preamble frame of the data-frame length is sent before any data.
- R4: If transmit enable is cleared during a frame, that frame completes. No further data frame starts, and the line rests at 1.
- R5: If transmit enable is cleared and set again while a frame is on the line, exactly one all-ones idle frame of the data-frame length follows the current frame.
- R6: With transmit enable on, a break request seen at a frame boundary sends an all-zero frame of the data-frame length. Once the request is low at a later boundary, a single 1 bit is sent.
- R7: While the break request stays high, break frames follow one another with no 1 bits between them.
- R8: A break sent while a preamble is pending replaces it. No preamble is sent afterwards.
- R9: While `mod_en`=0, `tx_en` has no effect. Data written during that time is not sent, and the line stays at 1.
- R10: `buf_empty` is 1 after reset. A write clears it, and it returns to 1 in the cycle after the buffered word moves into the shifter.
- R11: After reset `txd`=1 and `tx_done`=1. `tx_done` is 1 exactly when no frame is on the line, the buffer is empty and no preamble, idle or trailing-1 frame is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_en | input | 1 | Module enable; gates updates of transmit enable |
| tx_en | input | 1 | Transmit enable request |
| brk_req | input | 1 | Break request |
| nine_bit | input | 1 | 1 selects 9-bit frames |
| bit9 | input | 1 | Ninth data bit |
| baud_tick | input | 1 | One-cycle bit-rate strobe |
| wr_stb | input | 1 | Write strobe for the holding buffer |
| wr_data | input | DATA_W | Word to transmit |
| txd | output | 1 | Serial line, idles high |
| buf_empty | output | 1 | Holding buffer may be written |
| tx_done | output | 1 | Line quiet with nothing pending |

## Verification
Controls and writes are registered on the clock edge where they are sampled. Each decision about the next frame is made on a baud tick at a frame boundary, and the first bit of the chosen frame appears on `txd` one cycle after that tick. `buf_empty` rises one cycle after the transfer tick and falls one cycle after a write. The bench keeps a behavioural model that makes the same decisions at each rising edge and holds the line's pending bits as a queue. It compares `txd`, `buf_empty` and `tx_done` at every falling edge, so each result is checked in the cycle it is due. Directed checks at the reset state and around the disabled-module window tie these comparisons to the requirement under test.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  parameter int SERTX_DW = 8;

  typedef enum logic [2:0] {
    FK_NONE = 3'd0,
    FK_BRK  = 3'd1,
    FK_TRL  = 3'd2,
    FK_PRE  = 3'd3,
    FK_IDL  = 3'd4,
    FK_DAT  = 3'd5
  } frame_kind_t;
endpackage

// File: rtl/sertx_holdbuf.sv
module sertx_holdbuf #(
  parameter int DATA_W = sertx_pkg::SERTX_DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              xfer,
  output logic [DATA_W-1:0] buf_data,
  output logic              buf_empty
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_data  <= '0;
      buf_empty <= 1'b1;
    end else begin
      if (xfer)   buf_empty <= 1'b1;
      if (wr_stb) begin
        buf_data  <= wr_data;
        buf_empty <= 1'b0;
      end
    end
  end

  AST_EMPTY_AFTER_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !wr_stb) |=> buf_empty); // R10
  AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !buf_empty); // R10
endmodule

// File: rtl/sertx_ctrl.sv
module sertx_ctrl (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   mod_en,
  input  logic                   tx_en,
  input  logic                   brk_req,
  input  logic                   baud_tick,
  input  logic                   busy,
  input  logic                   last_bit,
  input  logic                   buf_empty,
  output logic                   frame_load,
  output sertx_pkg::frame_kind_t frame_kind,
  output logic                   xfer,
  output logic                   pend_any
);
  import sertx_pkg::*;

  logic te_q, pre_pend, idle_q, brk_owe;
  logic rise_evt, boundary, brk_now;

  assign rise_evt = mod_en & tx_en & ~te_q;
  assign boundary = baud_tick & (~busy | last_bit);
  assign brk_now  = brk_req & te_q;

  always_comb begin
    frame_kind = FK_NONE;
    if (brk_now)                  frame_kind = FK_BRK;
    else if (brk_owe)             frame_kind = FK_TRL;
    else if (te_q && pre_pend)    frame_kind = FK_PRE;
    else if (te_q && idle_q)      frame_kind = FK_IDL;
    else if (te_q && !buf_empty)  frame_kind = FK_DAT;
  end

  assign frame_load = boundary;
  assign xfer       = boundary && (frame_kind == FK_DAT);
  assign pend_any   = pre_pend | idle_q | brk_owe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      te_q     <= 1'b0;
      pre_pend <= 1'b0;
      idle_q   <= 1'b0;
      brk_owe  <= 1'b0;
    end else begin
      if (mod_en) te_q <= tx_en;
      if (boundary) begin
        case (frame_kind)
          FK_BRK: begin pre_pend <= 1'b0; brk_owe <= 1'b1; end
          FK_TRL: brk_owe  <= 1'b0;
          FK_PRE: pre_pend <= 1'b0;
          FK_IDL: idle_q   <= 1'b0;
          default: ;
        endcase
      end
      if (rise_evt) begin
        if (busy) idle_q   <= 1'b1;
        else      pre_pend <= 1'b1;
      end
    end
  end

  AST_TE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_en |=> $stable(te_q)); // R9
  AST_BRK_DROPS_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_load && frame_kind == FK_BRK) |=> !pre_pend); // R8
  AST_START_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && frame_load) |-> baud_tick); // R1
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter #(
  parameter int DATA_W = sertx_pkg::SERTX_DW
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   baud_tick,
  input  logic                   frame_load,
  input  sertx_pkg::frame_kind_t frame_kind,
  input  logic [DATA_W-1:0]      data,
  input  logic                   bit9,
  input  logic                   nine_bit,
  output logic                   txd,
  output logic                   busy,
  output logic                   last_bit
);
  import sertx_pkg::*;

  localparam int FW = DATA_W + 3;
  localparam int CW = $clog2(FW + 1);

  function automatic logic [CW-1:0] frame_len(frame_kind_t k, logic nine);
    if (k == FK_NONE) return '0;
    if (k == FK_TRL)  return CW'(1);
    return nine ? CW'(DATA_W + 3) : CW'(DATA_W + 2);
  endfunction

  function automatic logic [FW-1:0] frame_bits(frame_kind_t k, logic [DATA_W-1:0] d,
                                               logic b9, logic nine);
    logic [FW-1:0] v;
    v = '1;
    if (k == FK_BRK) v = '0;
    else if (k == FK_DAT) begin
      v[0]          = 1'b0;
      v[DATA_W:1]   = d;
      if (nine) v[DATA_W+1] = b9;
    end
    return v;
  endfunction

  logic [FW-1:0] sh_q;
  logic [CW-1:0] cnt_q;
  frame_kind_t   kind_q;

  assign busy     = (cnt_q != '0);
  assign last_bit = (cnt_q == CW'(1));
  assign txd      = busy ? sh_q[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      cnt_q  <= '0;
      kind_q <= FK_NONE;
    end else if (frame_load) begin
      sh_q   <= frame_bits(frame_kind, data, bit9, nine_bit);
      cnt_q  <= frame_len(frame_kind, nine_bit);
      kind_q <= frame_kind;
    end else if (baud_tick && busy) begin
      sh_q  <= {1'b1, sh_q[FW-1:1]};
      cnt_q <= cnt_q - CW'(1);
    end
  end

  AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && kind_q == FK_BRK) |-> !txd); // R6
  AST_FILLER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (kind_q == FK_PRE || kind_q == FK_IDL || kind_q == FK_TRL)) |-> txd); // R5
  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!baud_tick && !frame_load) |=> $stable(txd)); // R1
endmodule

// File: rtl/sertx_engine.sv
module sertx_engine #(
  parameter int DATA_W = sertx_pkg::SERTX_DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mod_en,
  input  logic              tx_en,
  input  logic              brk_req,
  input  logic              nine_bit,
  input  logic              bit9,
  input  logic              baud_tick,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  output logic              txd,
  output logic              buf_empty,
  output logic              tx_done
);
  import sertx_pkg::*;

  logic              busy, last_bit, frame_load, xfer, pend_any;
  frame_kind_t       frame_kind;
  logic [DATA_W-1:0] buf_data;

  sertx_holdbuf #(.DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
    .xfer(xfer), .buf_data(buf_data), .buf_empty(buf_empty)
  );

  sertx_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .tx_en(tx_en),
    .brk_req(brk_req), .baud_tick(baud_tick), .busy(busy),
    .last_bit(last_bit), .buf_empty(buf_empty), .frame_load(frame_load),
    .frame_kind(frame_kind), .xfer(xfer), .pend_any(pend_any)
  );

  sertx_shifter #(.DATA_W(DATA_W)) u_sh (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .frame_load(frame_load),
    .frame_kind(frame_kind), .data(buf_data), .bit9(bit9),
    .nine_bit(nine_bit), .txd(txd), .busy(busy), .last_bit(last_bit)
  );

  assign tx_done = ~busy & buf_empty & ~pend_any;

  AST_DONE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> txd); // R11
endmodule

// File: tb/sertx_engine_tb.sv
module sertx_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int WD_LIMIT = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mod_en = 1'b0, tx_en = 1'b0, brk_req = 1'b0, nine_bit = 1'b0, bit9 = 1'b0;
  logic baud_tick = 1'b0, wr_stb = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic txd, buf_empty, tx_done;

  int checks = 0, fails = 0, cyc = 0, div = 0;
  bit finished = 0;
  string cur_req = "R11";

  // behavioural model state
  bit m_te, m_pre, m_idle, m_owe, m_empty;
  bit [DW-1:0] m_buf;
  bit m_bits[$];

  sertx_engine #(.DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .tx_en(tx_en), .brk_req(brk_req),
    .nine_bit(nine_bit), .bit9(bit9), .baud_tick(baud_tick), .wr_stb(wr_stb),
    .wr_data(wr_data), .txd(txd), .buf_empty(buf_empty), .tx_done(tx_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    div = (div + 1) % 4;
    baud_tick = (div == 0);
  end

  function automatic bit m_txd();
    return (m_bits.size() > 0) ? m_bits[0] : 1'b1;
  endfunction

  function automatic bit m_done();
    return (m_bits.size() == 0) && m_empty && !m_pre && !m_idle && !m_owe;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_te = 0; m_pre = 0; m_idle = 0; m_owe = 0; m_empty = 1; m_buf = '0;
      m_bits.delete();
    end else begin
      bit busy_now, rise, bnd;
      int len;
      busy_now = m_bits.size() > 0;
      rise = mod_en && tx_en && !m_te;
      bnd  = baud_tick && (m_bits.size() <= 1);
      len  = nine_bit ? DW + 3 : DW + 2;
      if (bnd) begin
        bit [DW-1:0] d;
        d = m_buf;
        m_bits.delete();
        if (brk_req && m_te) begin
          for (int i = 0; i < len; i++) m_bits.push_back(1'b0);
          m_pre = 0; m_owe = 1;
        end else if (m_owe) begin
          m_bits.push_back(1'b1);
          m_owe = 0;
        end else if (m_te && m_pre) begin
          for (int i = 0; i < len; i++) m_bits.push_back(1'b1);
          m_pre = 0;
        end else if (m_te && m_idle) begin
          for (int i = 0; i < len; i++) m_bits.push_back(1'b1);
          m_idle = 0;
        end else if (m_te && !m_empty) begin
          m_bits.push_back(1'b0);
          for (int i = 0; i < DW; i++) m_bits.push_back(d[i]);
          if (nine_bit) m_bits.push_back(bit9);
          m_bits.push_back(1'b1);
          m_empty = 1;
        end
      end else if (baud_tick && m_bits.size() > 1) begin
        void'(m_bits.pop_front());
      end
      if (rise) begin
        if (busy_now) m_idle = 1;
        else          m_pre  = 1;
      end
      if (wr_stb) begin m_buf = wr_data; m_empty = 0; end
      if (mod_en) m_te = tx_en;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && !finished) begin
      chk(cur_req, "txd", txd, m_txd());
      chk(cur_req, "buf_empty", buf_empty, m_empty);
      chk(cur_req, "tx_done", tx_done, m_done());
    end
  end

  always @(negedge clk) begin
    if (cyc == WD_LIMIT && !finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_word(logic [DW-1:0] d);
    @(negedge clk);
    wr_data = d; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic write_when_empty(logic [DW-1:0] d);
    @(negedge clk);
    while (!buf_empty) @(negedge clk);
    write_word(d);
  endtask

  task automatic wait_done();
    @(negedge clk);
    while (!tx_done) @(negedge clk);
  endtask

  initial begin
    int zeros;
    wait_cyc(3);
    // R11: reset state, checked before release
    chk("R11", "reset txd", txd, 1);
    chk("R10", "reset buf_empty", buf_empty, 1);
    chk("R11", "reset tx_done", tx_done, 1);
    rst_n = 1'b1;
    wait_cyc(4);

    // R9: tx_en ignored while module disabled
    cur_req = "R9";
    tx_en = 1'b1;
    write_word(8'h81);
    zeros = 0;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      if (!txd) zeros++;
    end
    chk("R9", "line low cycles while disabled", zeros, 0);
    chk("R9", "buffered word kept", buf_empty, 0);
    tx_en = 1'b0;
    mod_en = 1'b1;
    wait_cyc(4);

    // R3 + R1: preamble then 8-bit data
    cur_req = "R3";
    tx_en = 1'b1;
    wait_cyc(60);
    cur_req = "R1";
    write_when_empty(8'hA5);
    write_when_empty(8'h3C);
    wait_done();

    // R2 + R3 in 9-bit mode
    cur_req = "R3";
    tx_en = 1'b0;
    wait_cyc(8);
    nine_bit = 1'b1;
    tx_en = 1'b1;
    wait_cyc(20);
    cur_req = "R2";
    bit9 = 1'b1;
    write_when_empty(8'h5A);
    wait_cyc(30);
    bit9 = 1'b0;
    write_when_empty(8'hC3);
    wait_done();

    // R4: enable dropped mid-frame
    cur_req = "R4";
    nine_bit = 1'b0;
    write_word(8'h0F);
    write_word(8'hF0);
    wait_cyc(20);
    tx_en = 1'b0;
    wait_cyc(150);
    chk("R4", "line idle after disable", txd, 1);
    tx_en = 1'b1;
    wait_done();

    // R5: off then on during a frame
    cur_req = "R5";
    write_word(8'h96);
    wait_cyc(14);
    tx_en = 1'b0;
    wait_cyc(2);
    tx_en = 1'b1;
    write_word(8'h69);
    wait_done();

    // R6: single break then trailing 1
    cur_req = "R6";
    wait_cyc(5);
    brk_req = 1'b1;
    wait_cyc(10);
    brk_req = 1'b0;
    wait_done();
    write_word(8'h55);
    wait_done();

    // R7: continuous break
    cur_req = "R7";
    brk_req = 1'b1;
    wait_cyc(130);
    brk_req = 1'b0;
    wait_done();

    // R8: break requested before preamble starts
    cur_req = "R8";
    tx_en = 1'b0;
    wait_cyc(8);
    brk_req = 1'b1;
    tx_en = 1'b1;
    wait_cyc(6);
    brk_req = 1'b0;
    wait_done();
    write_word(8'hE7);
    wait_done();
    chk("R11", "done at end", tx_done, 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule